// File: doc/BRIEF.md
# Converter Start/Stop Fault Sequencer

This block supervises the power stage of a bridge converter controller. It takes digitized comparator flags (two line-level flags, over-voltage, two bias undervoltage flags, over-temperature, a hiccup request and a configuration bit that forces hard stops) and orders the controller through shutdown, standby, run, soft-stop and hard-stop. It drives enable and clear controls for the main soft-start ramp and the rectifier soft-start ramp, the power output enable, the bias enable and the line hysteresis current select.

Both ramps are modelled as saturating digital counters. A step of `CHG_STEP` per clock is the charge rate. During a soft-stop the rectifier ramp winds down at three times that rate for a line standby request, or six times for a hiccup request. The main ramp is held until the rectifier ramp falls to the level that stands for 1.0 V, and then both ramps clear together. Every fault flag passes through a two-flop synchronizer before the state register sees it.

Top module: `pwr_stop_seq`

## Requirements
- R1: Line regions: `line_off_i`=1 gives shutdown (bias_en_o=0, out_en_o=0). `line_low_i`=1 with `line_off_i`=0 gives standby (bias_en_o=1, out_en_o=0). Both clear lets the converter run (out_en_o=1).
- R2: The main ramp leaves zero only when the line is above the run level and both bias undervoltage flags (and every other fault flag) are clear. While it charges, ss_en_o=1 and it rises by CHG_STEP (default 2) per clock, saturating at 2^RAMP_W-1.
- R3: The rectifier ramp stays at zero until the main ramp has reached LVL_2V (default 128). It then rises by CHG_STEP per clock, and sr_en_o=1 while it may charge.
- R4: Line standby while running starts a soft-stop: the rectifier ramp falls by 3*CHG_STEP (default 6) per clock, floored at zero.
- R5: During a soft-stop the main ramp keeps its value.
- R6: In a soft-stop, once the rectifier ramp is at or below LVL_1V (default 64), the next clock clears both ramps in the same cycle, drops out_en_o and enters standby.
- R7: A hiccup request while running starts a soft-stop in which the rectifier ramp falls by 6*CHG_STEP (default 12) per clock.
- R8: Over-voltage or either bias undervoltage flag causes a hard stop: on one clock out_en_o goes low and both ramps become zero.
- R9: With `force_hard_i`=1, a line standby or hiccup request while running causes a hard stop instead of a soft-stop.
- R10: A hard-stop fault during a soft-stop aborts it at once, with the same timing as R8.
- R11: Over-temperature forces shutdown (bias_en_o=0, ramps zero). After it clears, the block re-enters standby and then starts a full run from both ramps at zero.
- R12: Each fault input acts on the state, the ramps and the outputs on the third rising clock edge after it changes (two synchronizer flops plus the state register).
- R13: hyst_sel_o is the synchronized `line_low_i` and follows it on the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_off_i | input | 1 | Line below shutdown level |
| line_low_i | input | 1 | Line below run level |
| ovp_i | input | 1 | Over-voltage flag |
| vcc_uv_i | input | 1 | Gate-drive supply undervoltage |
| ref_uv_i | input | 1 | Reference supply undervoltage |
| otp_i | input | 1 | Over-temperature flag |
| hiccup_i | input | 1 | Hiccup restart request |
| force_hard_i | input | 1 | Configuration: every fault stops hard |
| bias_en_o | output | 1 | Bias regulators enabled |
| out_en_o | output | 1 | Power stage outputs enabled |
| ss_en_o | output | 1 | Main ramp charging |
| ss_clr_o | output | 1 | Main ramp held clear |
| sr_en_o | output | 1 | Rectifier ramp allowed to charge |
| sr_clr_o | output | 1 | Rectifier ramp held clear |
| hyst_sel_o | output | 1 | Line hysteresis current sink select |
| ss_lvl_o | output | RAMP_W | Main ramp level |
| sr_lvl_o | output | RAMP_W | Rectifier ramp level |

## Verification
The hysteresis select follows its input on the second rising edge, and the state, the ramps and every enable follow on the third. The bench drives inputs one nanosecond after a rising edge and samples one nanosecond after the edge where a result is due. It also samples one edge earlier to show that the old value still holds. Ramp levels are predicted by counting edges from the entry edge of a state: in run the main ramp equals twice the edge count, and in a soft-stop the rectifier ramp equals full scale minus the edge count times the wind-down step.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_STBY  = 2'd1,
    ST_RUN   = 2'd2,
    ST_SSTOP = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    RAMP_CLR  = 2'd0,
    RAMP_HOLD = 2'd1,
    RAMP_UP   = 2'd2,
    RAMP_DN   = 2'd3
  } ramp_cmd_e;

  typedef struct packed {
    logic force_hard;
    logic hiccup;
    logic otp;
    logic ref_uv;
    logic vcc_uv;
    logic ovp;
    logic line_low;
    logic line_off;
  } flt_in_t;

  localparam int unsigned FLT_W = $bits(flt_in_t);

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[g] <= '0;
      end else if (g == 0) begin
        stage_q[g] <= d_i;
      end else begin
        stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pwr_seq_ramp.sv
module pwr_seq_ramp
  import pwr_seq_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  ramp_cmd_e cmd_i,
  input  logic [W-1:0] up_step_i,
  input  logic [W-1:0] dn_step_i,
  output logic [W-1:0] lvl_o
);

  logic [W-1:0] lvl_q, lvl_d;
  logic [W:0]   sum;

  assign sum = {1'b0, lvl_q} + {1'b0, up_step_i};

  always_comb begin
    lvl_d = lvl_q;
    unique case (cmd_i)
      RAMP_CLR:  lvl_d = '0;
      RAMP_HOLD: lvl_d = lvl_q;
      RAMP_UP:   lvl_d = sum[W] ? '1 : sum[W-1:0];
      RAMP_DN:   lvl_d = (lvl_q < dn_step_i) ? '0 : lvl_q - dn_step_i;
      default:   lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_d;
  end

  assign lvl_o = lvl_q;

  assert_ramp_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == RAMP_HOLD) |=> $stable(lvl_o));

  assert_ramp_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == RAMP_CLR) |=> (lvl_o == '0));

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter int unsigned CHG_STEP = 2,
  parameter int unsigned LVL_1V   = 64,
  parameter int unsigned LVL_2V   = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  flt_in_t      flt_i,
  input  logic [W-1:0] ss_lvl_i,
  input  logic [W-1:0] sr_lvl_i,
  output seq_state_e   state_o,
  output ramp_cmd_e    ss_cmd_o,
  output ramp_cmd_e    sr_cmd_o,
  output logic [W-1:0] dn_step_o
);

  localparam logic [W-1:0] L1V      = W'(LVL_1V);
  localparam logic [W-1:0] L2V      = W'(LVL_2V);
  localparam logic [W-1:0] STEP_LN  = W'(3 * CHG_STEP);
  localparam logic [W-1:0] STEP_HIC = W'(6 * CHG_STEP);

  seq_state_e   state_q, state_d;
  logic [W-1:0] rate_q;
  logic         to_off, hard_flt, soft_req, enter_soft;

  assign to_off   = flt_i.line_off | flt_i.otp;
  assign hard_flt = flt_i.ovp | flt_i.vcc_uv | flt_i.ref_uv;
  assign soft_req = flt_i.line_low | flt_i.hiccup;

  always_comb begin
    state_d = state_q;
    if (state_q == ST_OFF) begin
      if (!to_off) state_d = ST_STBY;
    end else if (to_off) begin
      state_d = ST_OFF;
    end else if (hard_flt) begin
      state_d = ST_STBY;
    end else begin
      unique case (state_q)
        ST_STBY:  if (!soft_req) state_d = ST_RUN;
        ST_RUN:   if (soft_req) state_d = flt_i.force_hard ? ST_STBY : ST_SSTOP;
        ST_SSTOP: if (flt_i.force_hard || sr_lvl_i <= L1V) state_d = ST_STBY;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  assign enter_soft = (state_q == ST_RUN) && (state_d == ST_SSTOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      rate_q  <= STEP_LN;
    end else begin
      state_q <= state_d;
      if (enter_soft) rate_q <= flt_i.hiccup ? STEP_HIC : STEP_LN;
    end
  end

  assign dn_step_o = enter_soft ? (flt_i.hiccup ? STEP_HIC : STEP_LN) : rate_q;

  always_comb begin
    unique case (state_d)
      ST_RUN: begin
        ss_cmd_o = RAMP_UP;
        sr_cmd_o = (ss_lvl_i >= L2V) ? RAMP_UP : RAMP_HOLD;
      end
      ST_SSTOP: begin
        ss_cmd_o = RAMP_HOLD;
        sr_cmd_o = RAMP_DN;
      end
      default: begin
        ss_cmd_o = RAMP_CLR;
        sr_cmd_o = RAMP_CLR;
      end
    endcase
  end

  assign state_o = state_q;

  assert_line_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_i.line_off |=> (state_q == ST_OFF));

  assert_hard_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_flt |=> (state_q == ST_STBY || state_q == ST_OFF));

  assert_force_hard_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_i.force_hard && state_q == ST_RUN) |=> (state_q != ST_SSTOP));

  assert_otp_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_i.otp |=> (state_q == ST_OFF));

endmodule

// File: rtl/pwr_stop_seq.sv
module pwr_stop_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned RAMP_W      = 8,
  parameter int unsigned CHG_STEP    = 2,
  parameter int unsigned LVL_1V      = 64,
  parameter int unsigned LVL_2V      = 128,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_off_i,
  input  logic              line_low_i,
  input  logic              ovp_i,
  input  logic              vcc_uv_i,
  input  logic              ref_uv_i,
  input  logic              otp_i,
  input  logic              hiccup_i,
  input  logic              force_hard_i,
  output logic              bias_en_o,
  output logic              out_en_o,
  output logic              ss_en_o,
  output logic              ss_clr_o,
  output logic              sr_en_o,
  output logic              sr_clr_o,
  output logic              hyst_sel_o,
  output logic [RAMP_W-1:0] ss_lvl_o,
  output logic [RAMP_W-1:0] sr_lvl_o
);

  localparam logic [RAMP_W-1:0] UP_STEP = RAMP_W'(CHG_STEP);
  localparam logic [RAMP_W-1:0] L1V     = RAMP_W'(LVL_1V);
  localparam logic [RAMP_W-1:0] L2V     = RAMP_W'(LVL_2V);

  flt_in_t           flt_raw, flt_s;
  seq_state_e        state;
  ramp_cmd_e         ss_cmd, sr_cmd;
  logic [RAMP_W-1:0] dn_step;
  logic [RAMP_W-1:0] sr_unused_dn;

  assign flt_raw = '{force_hard: force_hard_i, hiccup: hiccup_i, otp: otp_i,
                     ref_uv: ref_uv_i, vcc_uv: vcc_uv_i, ovp: ovp_i,
                     line_low: line_low_i, line_off: line_off_i};

  pwr_seq_sync #(.W(FLT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (flt_raw),
    .q_o    (flt_s)
  );

  pwr_seq_fsm #(
    .W(RAMP_W), .CHG_STEP(CHG_STEP), .LVL_1V(LVL_1V), .LVL_2V(LVL_2V)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flt_i     (flt_s),
    .ss_lvl_i  (ss_lvl_o),
    .sr_lvl_i  (sr_lvl_o),
    .state_o   (state),
    .ss_cmd_o  (ss_cmd),
    .sr_cmd_o  (sr_cmd),
    .dn_step_o (dn_step)
  );

  // main ramp never winds down; only the rectifier ramp uses the stop rate
  assign sr_unused_dn = '0;

  pwr_seq_ramp #(.W(RAMP_W)) u_ss_ramp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (ss_cmd),
    .up_step_i (UP_STEP),
    .dn_step_i (sr_unused_dn),
    .lvl_o     (ss_lvl_o)
  );

  pwr_seq_ramp #(.W(RAMP_W)) u_sr_ramp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (sr_cmd),
    .up_step_i (UP_STEP),
    .dn_step_i (dn_step),
    .lvl_o     (sr_lvl_o)
  );

  assign bias_en_o  = (state != ST_OFF);
  assign out_en_o   = (state == ST_RUN) || (state == ST_SSTOP);
  assign ss_en_o    = (state == ST_RUN);
  assign ss_clr_o   = (state == ST_OFF) || (state == ST_STBY);
  assign sr_en_o    = (state == ST_RUN) && (ss_lvl_o >= L2V);
  assign sr_clr_o   = ss_clr_o;
  assign hyst_sel_o = flt_s.line_low;

  assert_release_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_lvl_o != '0 && $past(ss_lvl_o) == '0) |->
      $past(!flt_s.line_low && !flt_s.line_off && !flt_s.vcc_uv && !flt_s.ref_uv));

  assert_sr_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_lvl_o != '0) |-> (ss_lvl_o >= L2V));

  assert_soft_rate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state) == ST_SSTOP && state == ST_SSTOP) |->
      (sr_lvl_o == (($past(sr_lvl_o) > $past(dn_step)) ? $past(sr_lvl_o) - $past(dn_step) : '0)));

  assert_ss_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state) == ST_SSTOP && state == ST_SSTOP) |-> (ss_lvl_o == $past(ss_lvl_o)));

  assert_soft_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SSTOP && sr_lvl_o <= L1V) |=> (ss_lvl_o == '0 && sr_lvl_o == '0 && !out_en_o));

  assert_hard_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_s.ovp || flt_s.vcc_uv || flt_s.ref_uv || flt_s.otp) |=>
      (ss_lvl_o == '0 && sr_lvl_o == '0 && !out_en_o));

  assert_out_needs_bias_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_o |-> bias_en_o);

endmodule

// File: tb/sim_pwr_stop_seq.sv
module sim_pwr_stop_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_v = 8'h03;
  logic       bias_en, out_en, ss_en, ss_clr, sr_en, sr_clr, hyst_sel;
  logic [7:0] ss_lvl, sr_lvl;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pwr_stop_seq u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .line_off_i(in_v[0]), .line_low_i(in_v[1]), .ovp_i(in_v[2]),
    .vcc_uv_i(in_v[3]), .ref_uv_i(in_v[4]), .otp_i(in_v[5]),
    .hiccup_i(in_v[6]), .force_hard_i(in_v[7]),
    .bias_en_o(bias_en), .out_en_o(out_en), .ss_en_o(ss_en), .ss_clr_o(ss_clr),
    .sr_en_o(sr_en), .sr_clr_o(sr_clr), .hyst_sel_o(hyst_sel),
    .ss_lvl_o(ss_lvl), .sr_lvl_o(sr_lvl)
  );

  // {inputs[7:0], out_en, bias_en, ss_clr, hyst_sel}; inputs bit0 line_off .. bit7 force_hard
  localparam int NVEC = 14;
  localparam logic [11:0] VEC [NVEC] = '{
    {8'h03, 4'b0011}, {8'h02, 4'b0111}, {8'h00, 4'b1100}, {8'h04, 4'b0110},
    {8'h00, 4'b1100}, {8'h08, 4'b0110}, {8'h10, 4'b0110}, {8'h00, 4'b1100},
    {8'h20, 4'b0010}, {8'h00, 4'b1100}, {8'h40, 4'b0110}, {8'h00, 4'b1100},
    {8'h80, 4'b1100}, {8'h82, 4'b0111}
  };
  localparam string VREQ [NVEC] = '{
    "R1", "R1", "R1", "R8", "R2", "R8", "R8", "R2",
    "R11", "R11", "R7", "R2", "R9", "R9"
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic run_full(input logic [7:0] v);
    in_v = v;
    step(400);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    // reset state
    step(3);
    chk("R1 reset bias", int'(bias_en), 0);
    chk("R1 reset out", int'(out_en), 0);
    chk("R1 reset ss", int'(ss_lvl), 0);
    chk("R1 reset sr", int'(sr_lvl), 0);
    chk("R1 reset clr", int'(ss_clr), 1);
    rst_n = 1'b1;
    step(5);

    for (int i = 0; i < NVEC; i++) begin
      in_v = VEC[i][11:4];
      step(6);
      chk({VREQ[i], " vec out_en"}, int'(out_en), int'(VEC[i][3]));
      chk({VREQ[i], " vec bias_en"}, int'(bias_en), int'(VEC[i][2]));
      chk({VREQ[i], " vec ss_clr"}, int'(ss_clr), int'(VEC[i][1]));
      chk({"R13 vec hyst"}, int'(hyst_sel), int'(VEC[i][0]));
    end

    // standby without force, then latency of a release
    in_v = 8'h02;
    step(6);
    in_v = 8'h00;
    step(1);
    chk("R13 hyst before 2nd edge", int'(hyst_sel), 1);
    step(1);
    chk("R13 hyst at 2nd edge", int'(hyst_sel), 0);
    chk("R12 out before 3rd edge", int'(out_en), 0);
    step(1);
    chk("R12 out at 3rd edge", int'(out_en), 1);
    chk("R2 ss first step", int'(ss_lvl), 2);
    chk("R2 ss_en", int'(ss_en), 1);

    // rectifier gating at the 2V level
    step(63);
    chk("R2 ss at 64 steps", int'(ss_lvl), 128);
    chk("R3 sr still zero", int'(sr_lvl), 0);
    chk("R3 sr_en at level", int'(sr_en), 1);
    step(1);
    chk("R3 sr first step", int'(sr_lvl), 2);
    step(200);
    chk("R2 ss saturated", int'(ss_lvl), 255);
    chk("R3 sr saturated", int'(sr_lvl), 255);

    // line soft-stop
    in_v = 8'h02;
    step(3);
    chk("R4 sr first wind-down", int'(sr_lvl), 249);
    chk("R4 out still on", int'(out_en), 1);
    step(9);
    chk("R4 sr after 10", int'(sr_lvl), 195);
    chk("R5 ss held", int'(ss_lvl), 255);
    step(22);
    chk("R6 sr at 63", int'(sr_lvl), 63);
    chk("R5 ss held late", int'(ss_lvl), 255);
    chk("R6 out on before clear", int'(out_en), 1);
    step(1);
    chk("R6 ss cleared", int'(ss_lvl), 0);
    chk("R6 sr cleared", int'(sr_lvl), 0);
    chk("R6 out off", int'(out_en), 0);
    chk("R6 bias on", int'(bias_en), 1);

    // hiccup soft-stop
    run_full(8'h00);
    in_v = 8'h40;
    step(3);
    chk("R7 sr first wind-down", int'(sr_lvl), 243);
    step(15);
    chk("R7 sr at 63", int'(sr_lvl), 63);
    chk("R7 out on", int'(out_en), 1);
    step(1);
    chk("R7 ramps cleared", int'(ss_lvl) + int'(sr_lvl), 0);
    chk("R7 out off", int'(out_en), 0);

    // hard fault aborting a soft-stop
    run_full(8'h00);
    in_v = 8'h02;
    step(7);
    chk("R4 sr before abort", int'(sr_lvl), 225);
    in_v = 8'h06;
    step(2);
    chk("R10 still soft", int'(sr_lvl), 213);
    chk("R10 out still on", int'(out_en), 1);
    step(1);
    chk("R10 ss cleared", int'(ss_lvl), 0);
    chk("R10 sr cleared", int'(sr_lvl), 0);
    chk("R10 out off", int'(out_en), 0);

    // bias undervoltage hard stop
    run_full(8'h00);
    in_v = 8'h08;
    step(2);
    chk("R8 ss before", int'(ss_lvl), 255);
    step(1);
    chk("R8 ss cleared", int'(ss_lvl), 0);
    chk("R8 sr cleared", int'(sr_lvl), 0);
    chk("R8 out off", int'(out_en), 0);

    // forced hard stop on line standby and on hiccup
    run_full(8'h80);
    chk("R9 run with force", int'(ss_lvl), 255);
    in_v = 8'h82;
    step(2);
    chk("R9 sr before", int'(sr_lvl), 255);
    step(1);
    chk("R9 line hard sr", int'(sr_lvl), 0);
    chk("R9 line hard ss", int'(ss_lvl), 0);
    chk("R9 line hard out", int'(out_en), 0);
    run_full(8'h80);
    in_v = 8'hC0;
    step(3);
    chk("R9 hiccup hard sr", int'(sr_lvl), 0);
    chk("R9 hiccup hard out", int'(out_en), 0);

    // over-temperature and full restart
    run_full(8'h00);
    in_v = 8'h20;
    step(3);
    chk("R11 bias off", int'(bias_en), 0);
    chk("R11 ss cleared", int'(ss_lvl), 0);
    chk("R11 out off", int'(out_en), 0);
    in_v = 8'h00;
    step(3);
    chk("R11 standby bias", int'(bias_en), 1);
    chk("R11 standby out", int'(out_en), 0);
    step(1);
    chk("R11 restart out", int'(out_en), 1);
    chk("R11 restart ss", int'(ss_lvl), 2);
    chk("R11 restart sr", int'(sr_lvl), 0);
    chk("R11 sr_clr low", int'(sr_clr), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule